// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block sits beside the instruction fetch stage and turns the current fetch address into the next fetch address within the same cycle. A small direct-mapped table is indexed by word-address bits of the fetch PC. Each slot remembers whether it is in use, the upper address bits of the branch that owns it, where that branch went last time it was taken, and a 2-bit saturating direction counter. The owner's address is compared against the fetch PC before any stored target is used, so a slot left behind by another branch can never redirect fetch.

When the slot matches and its counter leans taken, the stored target is offered as the next PC. In every other case fetch continues sequentially at PC+4. A second port receives branches once they resolve. A taken branch with no slot claims one. A branch that already owns its slot trains the counter and, when taken, refreshes the target. Lookups are combinational and updates land on the clock edge, so a lookup and an update to the same slot in one cycle see the table as it was before that edge.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is empty, so every fetch address reports no hit and next_pc equals fetch_pc+4.
- R2: The slot is chosen by fetch_pc[IDX_W+1:2] (IDX_W = log2 of the slot count). A hit requires the slot to be in use and its stored bits to equal fetch_pc[PC_W-1:IDX_W+2]. An address with the same slot bits but different upper bits misses.
- R3: On a hit whose counter is 2 or 3 (MSB set), pred_taken is 1 and next_pc equals the stored target.
- R4: On a miss, or on a hit whose counter is 0 or 1, pred_taken is 0 and next_pc equals fetch_pc+4.
- R5: A resolved taken branch that misses claims its slot: it stores the branch's upper bits and target and sets the counter to 2. Any previous owner of that slot is evicted.
- R6: A resolved not-taken branch that misses changes nothing in the table.
- R7: A resolved branch that hits moves the counter one step toward its outcome and saturates at 0 and 3. A taken outcome overwrites the target. A not-taken outcome keeps it.
- R8: When an update and a lookup address the same slot in the same cycle, the lookup reports the contents from before the update. The update is visible from the next cycle.
- R9: pred_hit reports a tag match whatever the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched |
| next_pc | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | Fetch address owns its slot |
| pred_taken | output | 1 | Redirect to stored target |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Resolved target address |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The assertions assume that fetch and update addresses are word aligned, because the two low bits take no part in either indexing or matching. They also assume that the upper bits are the only thing that tells two branches sharing a slot apart. The stimulus uses only multiples of four, and it builds slot conflicts by adding one slot stride times the slot count to a base address. Update inputs are always defined while upd_valid is high. The bench sweeps every slot through allocation, the full counter range with saturation at both ends, eviction, target refresh and same-cycle collisions, and it compares each cycle against its own table model.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] dir_ctr_t;

  localparam dir_ctr_t CTR_WEAK_TAKEN = 2'd2;
  localparam dir_ctr_t CTR_MAX        = 2'd3;
  localparam dir_ctr_t CTR_MIN        = 2'd0;

  // Saturating step of the direction counter toward the resolved outcome.
  function automatic dir_ctr_t ctr_train(input dir_ctr_t cur, input logic went);
    dir_ctr_t res;
    if (went) res = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else      res = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return res;
  endfunction

  // A counter predicts taken when its upper bit is set.
  function automatic logic ctr_says_taken(input dir_ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/btb_entry_array.sv
module btb_entry_array
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int TAG_W   = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  dir_ctr_t         wr_ctr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_tgt,
  output dir_ctr_t         rd_ctr,
  input  logic [IDX_W-1:0] ur_idx,
  output logic             ur_valid,
  output logic [TAG_W-1:0] ur_tag,
  output logic [PC_W-1:0]  ur_tgt,
  output dir_ctr_t         ur_ctr
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  dir_ctr_t           ctr_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n)   valid_q[e] <= 1'b0;
      else if (sel) valid_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_tgt;
        ctr_q[e] <= wr_ctr;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_tgt   = tgt_q[rd_idx];
  assign rd_ctr   = ctr_q[rd_idx];

  assign ur_valid = valid_q[ur_idx];
  assign ur_tag   = tag_q[ur_idx];
  assign ur_tgt   = tgt_q[ur_idx];
  assign ur_ctr   = ctr_q[ur_idx];

  // R1: the first cycle out of reset finds every slot empty
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0));

  // R5: a written slot is in use on the following cycle
  a_r5_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_tgt,
  input  dir_ctr_t         rd_ctr,
  output logic             lk_hit,
  output logic             lk_taken,
  output logic [PC_W-1:0]  next_pc
);

  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  logic [TAG_W-1:0] fetch_tag;
  logic             unused_fetch_lo;
  logic [PC_W-1:0]  fall_pc;

  assign rd_idx          = fetch_pc[IDX_W+1:2];
  assign fetch_tag       = fetch_pc[PC_W-1:IDX_W+2];
  assign unused_fetch_lo = ^fetch_pc[1:0];
  assign fall_pc         = seq_pc(fetch_pc);

  assign lk_hit   = rd_valid && (rd_tag == fetch_tag);
  assign lk_taken = lk_hit && ctr_says_taken(rd_ctr);
  assign next_pc  = lk_taken ? rd_tgt : fall_pc;

  // R4: without a taken hit fetch goes on sequentially
  a_r4_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_taken |-> (next_pc == fetch_pc + PC_W'(4)));

  // R3: a redirect only ever comes from a matching slot
  a_r3_redirect_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> (lk_hit && next_pc == rd_tgt));

  // R2: an empty slot never matches
  a_r2_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !lk_hit);

endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [PC_W-1:0]  upd_target,
  input  logic             upd_taken,
  output logic [IDX_W-1:0] ur_idx,
  input  logic             ur_valid,
  input  logic [TAG_W-1:0] ur_tag,
  input  logic [PC_W-1:0]  ur_tgt,
  input  dir_ctr_t         ur_ctr,
  output logic             upd_hit,
  output logic             upd_alloc,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output logic [PC_W-1:0]  wr_tgt,
  output dir_ctr_t         wr_ctr
);

  logic [TAG_W-1:0] upd_tag;
  logic             unused_upd_lo;

  assign ur_idx        = upd_pc[IDX_W+1:2];
  assign upd_tag       = upd_pc[PC_W-1:IDX_W+2];
  assign unused_upd_lo = ^upd_pc[1:0];

  assign upd_hit   = upd_valid && ur_valid && (ur_tag == upd_tag);
  assign upd_alloc = upd_valid && !upd_hit && upd_taken;

  always_comb begin
    wr_en  = upd_hit || upd_alloc;
    wr_idx = ur_idx;
    wr_tag = upd_tag;
    wr_tgt = upd_taken ? upd_target : ur_tgt;
    wr_ctr = upd_hit ? ctr_train(ur_ctr, upd_taken) : CTR_WEAK_TAKEN;
  end

  // R5: a fresh slot starts weakly taken
  a_r5_alloc_weak: assert property (@(posedge clk) disable iff (!rst_n)
    upd_alloc |-> (wr_en && wr_ctr == CTR_WEAK_TAKEN && wr_tgt == upd_target));

  // R6: a not-taken branch without a slot writes nothing
  a_r6_nt_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !upd_hit) |-> !wr_en);

  // R7: counters saturate at both ends
  a_r7_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && upd_taken && ur_ctr == CTR_MAX) |-> (wr_ctr == CTR_MAX));
  a_r7_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && !upd_taken && ur_ctr == CTR_MIN) |-> (wr_ctr == CTR_MIN));

  // R7: a not-taken outcome keeps the stored target
  a_r7_keep_target: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && !upd_taken) |-> (wr_tgt == ur_tgt));

  // no write is ever issued without a resolved branch
  a_r6_write_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> upd_valid);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0] rd_idx, ur_idx, wr_idx;
  logic             rd_valid, ur_valid;
  logic [TAG_W-1:0] rd_tag, ur_tag, wr_tag;
  logic [PC_W-1:0]  rd_tgt, ur_tgt, wr_tgt;
  dir_ctr_t         rd_ctr, ur_ctr, wr_ctr;
  logic             wr_en, upd_hit, upd_alloc;
  logic             lk_hit, lk_taken;

  btb_entry_array #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt), .rd_ctr(rd_ctr),
    .ur_idx(ur_idx), .ur_valid(ur_valid), .ur_tag(ur_tag), .ur_tgt(ur_tgt), .ur_ctr(ur_ctr)
  );

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt), .rd_ctr(rd_ctr),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .next_pc(next_pc)
  );

  btb_update_ctl #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_update (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken),
    .ur_idx(ur_idx), .ur_valid(ur_valid), .ur_tag(ur_tag), .ur_tgt(ur_tgt), .ur_ctr(ur_ctr),
    .upd_hit(upd_hit), .upd_alloc(upd_alloc),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  assign pred_hit   = lk_hit;
  assign pred_taken = lk_taken;

  // R8: a same-slot write does not disturb this cycle's prediction
  a_r8_old_contents: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx && !rd_valid) |-> !pred_hit);

  // R9: a taken prediction always comes with a hit
  a_r9_taken_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

endmodule

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] next_pc;
  logic        pred_hit, pred_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic        upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;

  bit          mv [N];
  logic [25:0] mt [N];
  logic [31:0] mg [N];
  int          mc [N];

  always #5 clk = ~clk;

  btb_predictor #(.ENTRIES(N), .PC_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken)
  );

  function automatic int slot_of(input logic [31:0] pc);
    return int'((pc / 4) % N);
  endfunction

  function automatic logic [25:0] upper_of(input logic [31:0] pc);
    return 26'(pc / (4 * N));
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One cycle: drive, compare against the model before the edge, then advance the model.
  task automatic cyc(input logic [31:0] f, input bit u, input logic [31:0] up,
                     input logic [31:0] ut, input bit tk, input string req);
    int s;
    bit eh, et;
    logic [31:0] en;
    @(negedge clk);
    fetch_pc = f; upd_valid = u; upd_pc = up; upd_target = ut; upd_taken = tk;
    #1;
    s  = slot_of(f);
    eh = mv[s] && (mt[s] == upper_of(f));
    et = eh && (mc[s] >= 2);
    en = et ? mg[s] : f + 32'd4;
    checks++;
    if (pred_hit !== eh || pred_taken !== et || next_pc !== en) begin
      errors++;
      $display("FAIL %s pc=%h: hit=%b taken=%b next=%h, expected hit=%b taken=%b next=%h",
               req, f, pred_hit, pred_taken, next_pc, eh, et, en);
    end
    @(posedge clk);
    if (u) begin
      s = slot_of(up);
      if (mv[s] && mt[s] == upper_of(up)) begin
        mc[s] = tk ? ((mc[s] == 3) ? 3 : mc[s] + 1) : ((mc[s] == 0) ? 0 : mc[s] - 1);
        if (tk) mg[s] = ut;
      end else if (tk) begin
        mv[s] = 1'b1; mt[s] = upper_of(up); mg[s] = ut; mc[s] = 2;
      end
    end
  endtask

  task automatic sweep_check(input logic [31:0] base, input string req);
    for (int i = 0; i < N; i++) cyc(base + 32'(i * 4), 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic sweep_train(input logic [31:0] base, input bit tk, input string req);
    for (int i = 0; i < N; i++)
      cyc(base + 32'(i * 4), 1'b1, base + 32'(i * 4), 32'h0008_0000 + 32'(i * 16), tk, req);
  endtask

  localparam logic [31:0] BASE  = 32'h0000_1000;
  localparam logic [31:0] ALIAS = 32'h0000_1000 + 32'(4 * N);

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mt[i] = '0; mg[i] = '0; mc[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    sweep_check(BASE, "R1 reset empty");
    sweep_train(BASE, 1'b0, "R6 nt miss");
    sweep_check(BASE, "R6 no allocation");
    sweep_train(BASE, 1'b1, "R5 allocate");
    sweep_check(BASE, "R3 weak taken redirect");
    sweep_train(BASE, 1'b0, "R7 down to 1");
    sweep_check(BASE, "R4 R9 hit not taken");
    sweep_train(BASE, 1'b0, "R7 down to 0");
    sweep_train(BASE, 1'b0, "R7 saturate low");
    sweep_check(BASE, "R4 strong not taken");
    sweep_train(BASE, 1'b1, "R7 up to 1");
    sweep_check(BASE, "R4 weak not taken");
    sweep_train(BASE, 1'b1, "R7 up to 2");
    sweep_train(BASE, 1'b1, "R7 up to 3");
    sweep_train(BASE, 1'b1, "R7 saturate high");
    sweep_train(BASE, 1'b0, "R7 back to 2");
    sweep_check(BASE, "R3 still taken");

    // target refresh on taken hit, kept on not-taken hit
    for (int i = 0; i < N; i++)
      cyc(BASE, 1'b1, BASE + 32'(i * 4), 32'h000C_0000 + 32'(i * 8), 1'b1, "R7 new target");
    sweep_check(BASE, "R7 target refreshed");
    for (int i = 0; i < N; i++)
      cyc(BASE, 1'b1, BASE + 32'(i * 4), 32'hDEAD_0000, 1'b0, "R7 nt keeps target");
    sweep_check(BASE, "R7 target kept");

    // conflicting addresses in the same slots
    sweep_check(ALIAS, "R2 alias miss");
    for (int i = 0; i < N; i++)
      cyc(ALIAS + 32'(i * 4), 1'b1, ALIAS + 32'(i * 4), 32'h0010_0000 + 32'(i * 4), 1'b0, "R6 alias nt");
    sweep_check(BASE, "R6 owner kept");
    sweep_train(ALIAS, 1'b1, "R5 evict");
    sweep_check(BASE, "R2 evicted owner misses");
    sweep_check(ALIAS, "R3 new owner");

    // same-cycle lookup and update of one slot
    for (int i = 0; i < N; i++) begin
      cyc(ALIAS + 32'(i * 4), 1'b1, ALIAS + 32'(i * 4), '0, 1'b0, "R8 old seen");
      cyc(ALIAS + 32'(i * 4), 1'b0, '0, '0, 1'b0, "R8 new seen");
    end
    for (int i = 0; i < N; i++)
      cyc(BASE + 32'(i * 4), 1'b1, BASE + 32'(i * 4), 32'h0020_0000, 1'b1, "R8 alloc same cycle");
    sweep_check(BASE, "R8 after alloc");

    // reset clears again
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < N; i++) mv[i] = 0;
    @(negedge clk); rst_n = 1'b1;
    sweep_check(BASE, "R1 reset again");

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
    $finish;
  end

endmodule